// File: doc/BRIEF.md
# Morse Message Playback Sequencer

This block replays a fixed Morse-code message, held as a 128-bit on-off keying pattern, on a single keying output that switches a carrier on (1) and off (0). The pattern is stored as four 32-bit words. A slow base tick, one system-clock cycle wide per tick, is divided down so that each stored bit lasts 16 ticks. A 5-bit position counter walks across the bits of the current word, and a one-hot word-line selector moves through the four words in order.

The selected bit is not driven straight to the output. A retiming register captures it a fixed number of ticks into each bit period, after the position and word selection have settled, so the key line never shows a glitch at a bit boundary. After the last word, a one-cycle done strobe is raised and playback starts again from word 0. The position counter leaves reset at 1, not 0, so the stored pattern starts at flat position 1 (flat position = word × 32 + bit position). The message repeats without end.

Top module: `morse_player`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `key_out` to 0, sets `word_line` to 4'b0001, sets `bit_idx` to 1 and holds `msg_done` at 0. This holds whatever `tick_en` does.
- R2: A clock edge with `tick_en` low changes none of the outputs and leaves the tick count inside the bit period unchanged.
- R3: `bit_idx` advances by one on the edge that takes the 16th tick of a bit period. It does not advance on any other tick.
- R4: `key_out` loads the stored bit of the current position on the edge that takes the 3rd tick of a bit period (tick offset 2). It holds that value until the same point of the next period.
- R5: `word_line` is always exactly one-hot. It rotates to the next word on the same tick on which `bit_idx` wraps from 31 to 0.
- R6: Words play in the order 0, 1, 2, 3 and then 0 again. Bit positions play in ascending order within each word.
- R7: `msg_done` is high for exactly one clock cycle after the tick that ends position 31 of word 3. In that cycle `word_line` is 4'b0001 and `bit_idx` is 0. It is low at all other times.
- R8: With the default pattern, `key_out` spells "UMAINE ECE" starting at flat position 1. The encoding is: a dot is one 1, a dash is three 1s, elements within a letter are separated by one 0, letters by three 0s and words by seven 0s. The 69 message bits occupy flat positions 1 to 69, and all other positions are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Base timing tick, one cycle wide |
| key_out | output | 1 | Carrier enable: 1 keys the carrier on |
| word_line | output | 4 | One-hot selector of the word being played |
| bit_idx | output | 5 | Bit position inside the current word |
| msg_done | output | 1 | One-cycle pulse when the message has finished |

## Verification
The embedded properties make no assumption about how often `tick_en` is raised. They need only that `rst_n` is low for at least one clock edge before the first checked cycle, and that the sample offset is smaller than the bit length. The stimulus respects this: it always starts with a reset of several edges and uses the default timing parameters. Ticks are driven as isolated one-cycle pulses separated by idle cycles, so every R2 hold property is exercised between ticks. One scenario adds a long idle gap, and another holds `tick_en` high throughout a reset.

// File: rtl/morse_pkg.sv
// morse_pkg: shared defaults for the Morse playback sequencer.
// Assumes: the pattern is a flat vector where bit k is word k/32, position k%32.
package morse_pkg;
    localparam int DEF_TICKS_PER_BIT = 16;
    localparam int DEF_SAMPLE_AT     = 2;
    localparam int DEF_NUM_WORDS     = 4;
    localparam int DEF_WORD_BITS     = 32;
    // "UMAINE ECE" keyed from flat position 1 upward, zeros elsewhere.
    localparam logic [127:0] DEF_PATTERN = 128'h0000_0000_0000_0022_EB88_08B8_A3A3_B8EA;
endpackage

// File: rtl/tick_divider.sv
// tick_divider: counts base ticks inside one bit period.
// Raises period_end on the last tick of a period and sample_now on tick
// SAMPLE_AT. Assumes SAMPLE_AT < TICKS_PER_BIT and tick_en one cycle per tick.
module tick_divider #(
    parameter int TICKS_PER_BIT = 16,
    parameter int SAMPLE_AT     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic period_end,
    output logic sample_now
);
    localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [TCW-1:0] LAST_TICK = TCW'(TICKS_PER_BIT - 1);
    localparam logic [TCW-1:0] SAMPLE_TICK = TCW'(SAMPLE_AT);

    logic [TCW-1:0] tick_cnt;

    // Strobes decoded from the tick count on the ticking cycle.
    always_comb begin
        period_end = tick_en && (tick_cnt == LAST_TICK);
        sample_now = tick_en && (tick_cnt == SAMPLE_TICK);
    end

    // Tick counter inside the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (period_end)
            tick_cnt <= '0;
        else if (tick_en)
            tick_cnt <= tick_cnt + 1'b1;
    end

    assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tick_cnt));
    assert_period_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (tick_cnt == '0));
endmodule

// File: rtl/position_sequencer.sv
// position_sequencer: steps the bit position and the one-hot word line.
// Starts at position 1 of word 0. The word line rotates when the position
// wraps. A done pulse follows the last word. Assumes NUM_WORDS >= 2.
module position_sequencer #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_BITS = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    output logic [NUM_WORDS-1:0]         word_sel,
    output logic [$clog2(WORD_BITS)-1:0] bit_pos,
    output logic                         done
);
    localparam int BCW = $clog2(WORD_BITS);
    localparam logic [BCW-1:0] LAST_POS  = BCW'(WORD_BITS - 1);
    localparam logic [BCW-1:0] START_POS = BCW'(1);

    // Position counter, word-line rotation and the done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_pos  <= START_POS;
            word_sel <= NUM_WORDS'(1);
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (advance) begin
                if (bit_pos == LAST_POS) begin
                    bit_pos  <= '0;
                    word_sel <= {word_sel[NUM_WORDS-2:0], word_sel[NUM_WORDS-1]};
                    done     <= word_sel[NUM_WORDS-1];
                end else begin
                    bit_pos <= bit_pos + 1'b1;
                end
            end
        end
    end

    assert_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(word_sel) == 1);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(bit_pos) && $stable(word_sel)));
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && bit_pos == LAST_POS) |=> (bit_pos == '0 && word_sel != $past(word_sel)));
    assert_done_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (word_sel[0] && bit_pos == '0));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/key_retimer.sv
// key_retimer: selects the stored bit for the current word and position.
// Registers it into the key output on the sample strobe. Assumes word_sel
// is one-hot; the selection is an AND-OR over the word lines.
module key_retimer #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_BITS = 32,
    parameter logic [NUM_WORDS*WORD_BITS-1:0] PATTERN = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_now,
    input  logic [NUM_WORDS-1:0]         word_sel,
    input  logic [$clog2(WORD_BITS)-1:0] bit_pos,
    output logic                         key
);
    logic [NUM_WORDS-1:0] word_hit;
    logic                 sel_bit;

    // One read port per word line, gated by that line.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [WORD_BITS-1:0] WORD_VAL = PATTERN[w*WORD_BITS +: WORD_BITS];
        assign word_hit[w] = word_sel[w] & WORD_VAL[bit_pos];
    end

    // Merge of the gated word outputs.
    always_comb sel_bit = |word_hit;

    // Mid-period capture of the selected bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key <= 1'b0;
        else if (sample_now)
            key <= sel_bit;
    end

    assert_key_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_now |=> $stable(key));
endmodule

// File: rtl/morse_player.sv
// morse_player: plays a stored on-off keyed Morse pattern in an endless loop.
// Each bit lasts TICKS_PER_BIT base ticks and is sampled at tick SAMPLE_AT.
// Assumes SAMPLE_AT < TICKS_PER_BIT and a power-of-two WORD_BITS.
module morse_player #(
    parameter int TICKS_PER_BIT = morse_pkg::DEF_TICKS_PER_BIT,
    parameter int SAMPLE_AT     = morse_pkg::DEF_SAMPLE_AT,
    parameter int NUM_WORDS     = morse_pkg::DEF_NUM_WORDS,
    parameter int WORD_BITS     = morse_pkg::DEF_WORD_BITS,
    parameter logic [NUM_WORDS*WORD_BITS-1:0] PATTERN = morse_pkg::DEF_PATTERN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_en,
    output logic                         key_out,
    output logic [NUM_WORDS-1:0]         word_line,
    output logic [$clog2(WORD_BITS)-1:0] bit_idx,
    output logic                         msg_done
);
    logic period_end;
    logic sample_now;

    tick_divider #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .SAMPLE_AT    (SAMPLE_AT)
    ) u_tick_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .period_end(period_end),
        .sample_now(sample_now)
    );

    position_sequencer #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_BITS(WORD_BITS)
    ) u_position_sequencer (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (period_end),
        .word_sel(word_line),
        .bit_pos (bit_idx),
        .done    (msg_done)
    );

    key_retimer #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_BITS(WORD_BITS),
        .PATTERN  (PATTERN)
    ) u_key_retimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_now(sample_now),
        .word_sel  (word_line),
        .bit_pos   (bit_idx),
        .key       (key_out)
    );
endmodule

// File: tb/morse_player_bench.sv
// morse_player_bench: directed scenarios against an independent Morse encoder.
module morse_player_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       key_out;
    logic [3:0] word_line;
    logic [4:0] bit_idx;
    logic       msg_done;

    int checks = 0;
    int errors = 0;
    logic last_done = 1'b0;
    logic [127:0] exp_bits;

    always #2.5 clk = ~clk;

    morse_player u_morse_player (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .key_out  (key_out),
        .word_line(word_line),
        .bit_idx  (bit_idx),
        .msg_done (msg_done)
    );

    function automatic string code_of(byte c);
        case (c)
            "A": return ".-";
            "C": return "-.-.";
            "E": return ".";
            "I": return "..";
            "M": return "--";
            "N": return "-.";
            "U": return "..-";
            default: return "";
        endcase
    endfunction

    // Encode text into keyed bits from flat position 1.
    function automatic logic [127:0] encode(string txt);
        logic [127:0] v = '0;
        int pos = 1;
        int gap = 0;
        for (int i = 0; i < txt.len(); i++) begin
            if (txt[i] == " ") begin
                gap = 7;
            end else begin
                string s = code_of(txt[i]);
                pos += gap;
                for (int e = 0; e < s.len(); e++) begin
                    if (e > 0) pos += 1;
                    if (s[e] == "-") begin
                        v[pos] = 1'b1; v[pos+1] = 1'b1; v[pos+2] = 1'b1;
                        pos += 3;
                    end else begin
                        v[pos] = 1'b1;
                        pos += 1;
                    end
                end
                gap = 3;
            end
        end
        return v;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        last_done = msg_done;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        check(key_out == 1'b0, {tag, " R1 key"}, key_out, 0);
        check(word_line == 4'b0001, {tag, " R1 word_line"}, word_line, 1);
        check(bit_idx == 5'd1, {tag, " R1 bit_idx"}, bit_idx, 1);
        check(msg_done == 1'b0, {tag, " R1 done"}, msg_done, 0);
    endtask

    // R1: reset values after power-up.
    task automatic t_reset();
        do_reset();
        check_reset_state("power-up");
    endtask

    // R4/R3: sample point and bit length.
    task automatic t_sample_point();
        do_reset();
        do_tick(); do_tick();
        check(key_out == 1'b0, "R4 key before sample", key_out, 0);
        do_tick();
        check(key_out == exp_bits[1], "R4 key at tick 2", key_out, exp_bits[1]);
        repeat (12) do_tick();
        check(bit_idx == 5'd1, "R3 no advance at tick 15", bit_idx, 1);
        do_tick();
        check(bit_idx == 5'd2, "R3 advance at tick 16", bit_idx, 2);
        check(key_out == exp_bits[1], "R4 key held past boundary", key_out, exp_bits[1]);
        do_tick(); do_tick();
        check(key_out == exp_bits[1], "R4 key held before sample", key_out, exp_bits[1]);
        do_tick();
        check(key_out == exp_bits[2], "R4 key next sample", key_out, exp_bits[2]);
    endtask

    // R2: idle cycles change nothing and keep the tick count.
    task automatic t_idle();
        logic k;
        do_reset();
        repeat (5) do_tick();
        k = key_out;
        repeat (40) @(negedge clk);
        check(key_out == k, "R2 key idle", key_out, k);
        check(bit_idx == 5'd1, "R2 bit_idx idle", bit_idx, 1);
        check(word_line == 4'b0001, "R2 word_line idle", word_line, 1);
        repeat (10) do_tick();
        check(bit_idx == 5'd1, "R2 count kept (15 ticks)", bit_idx, 1);
        do_tick();
        check(bit_idx == 5'd2, "R2 count kept (16 ticks)", bit_idx, 2);
    endtask

    // R5/R6/R7/R8: two full passes compared with the encoder.
    task automatic t_full_message();
        int w = 0;
        int b = 1;
        do_reset();
        for (int p = 0; p < 255; p++) begin
            logic exp_done = 1'b0;
            for (int t = 0; t < 16; t++) begin
                do_tick();
                if (t == 0)
                    check(last_done == 1'b0, "R7 done low", last_done, 0);
                if (t == 2)
                    check(key_out == exp_bits[w*32+b], "R8 key bit", key_out, exp_bits[w*32+b]);
            end
            if (b == 31) begin
                b = 0;
                if (w == 3) begin w = 0; exp_done = 1'b1; end
                else w++;
            end else b++;
            check(last_done == exp_done, "R7 done at end", last_done, exp_done);
            check(bit_idx == 5'(b), "R6 bit order", bit_idx, b);
            check(word_line == 4'(1 << w), "R5 word one-hot order", word_line, 1 << w);
        end
    endtask

    // R1: reset in mid-message with tick_en held high.
    task automatic t_reset_mid();
        repeat (40) do_tick();
        @(negedge clk) begin rst_n = 1'b0; tick_en = 1'b1; end
        repeat (3) @(negedge clk);
        check_reset_state("in reset");
        tick_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("mid-message");
    endtask

    initial begin
        exp_bits = encode("UMAINE ECE");
        t_reset();
        t_sample_point();
        t_idle();
        t_full_message();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule